// File: doc/BRIEF.md
# Byte-Code Configuration Sequencer

The sequencer walks a byte-coded instruction stream and moves configuration bytes between a register map and a nonvolatile storage array. It runs in one of two directions. In a save run it reads the stream from a scratch-pad memory and copies every instruction byte into storage. For each transfer instruction it also copies the register-map bytes the instruction names. In a load run it reads the stored stream back from storage address 0 and writes the transfer payloads into the register map. On the way it fires side-effect strobes for register update, calibration and output sync.

A condition tag board lets one stored image serve several board variants. Condition opcodes tag condition numbers. A transfer executes only when no tag is set or when the externally selected condition is tagged. Skipped transfers are still parsed so that the stream stays aligned. A pause opcode ends a save run but leaves the storage pointer on the pause byte. The next save run then continues the image from that address and overwrites the pause.

All three memories have a combinational read and a registered write. The sequencer consumes one byte per clock cycle. A run starts with a one-cycle `start` pulse and finishes with a one-cycle `done` pulse.

Top module: `cfg_bytecode_seq`

## Requirements
- R1: After reset, `busy`, `done`, all three strobes, `st_we` and `rm_we` are low. No write is issued to any memory while `busy` is low.
- R2: In a save run (`dir_save`=1), the scratch-pad bytes are copied one per cycle to consecutive storage addresses. A transfer opcode N (0x00..0x7F) is stored, then its two address bytes (high first), then the N+1 register-map bytes read from consecutive addresses starting at (high<<8 | low) modulo the register-map size.
- R3: In a load run (`dir_save`=0), the stream is read from storage starting at address 0. An executed transfer opcode N writes the N+1 payload bytes that follow its address bytes into consecutive register-map addresses, starting at the given address.
- R4: Opcode 0x80 pulses `upd_stb`, 0xA0 pulses `cal_stb` and 0xA1 pulses `sync_stb`. Each pulse lasts one cycle, at most one strobe is high at a time, and the pulses come in stream order. Strobes fire during load runs only and are not gated by conditions.
- R5: Opcodes 0xB1..0xB8 tag conditions 1..8, and 0xB0 clears every tag. While any tag is set, a transfer writes only if `sel_cond` is in 1..8 and that condition is tagged. A skipped transfer still consumes its address and payload bytes.
- R6: Opcodes 0xB9..0xCF, and every other byte of 0x81..0xFD not named in R4 or R5, are one-byte no-operations.
- R7: A save run that reaches 0xFE stores it and leaves the pointer on it. The next save run starts writing at that address. A load run clears this append state.
- R8: A save run that reaches 0xFF stores it, and the next save run starts at storage address 0.
- R9: On reaching 0xFE or 0xFF, `busy` falls and `done` is high for exactly one cycle. `start` is ignored while `busy` is high.
- R10: The tag board is cleared at the start of every run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start a run (sampled while idle) |
| dir_save | input | 1 | 1 = save to storage, 0 = load from storage |
| sel_cond | input | 4 | Condition number the system is in (0 = none) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| sp_addr | output | SP_AW | Scratch-pad read address |
| sp_rdata | input | 8 | Scratch-pad read data |
| st_addr | output | ST_AW | Storage address (pointer) |
| st_rdata | input | 8 | Storage read data |
| st_wdata | output | 8 | Storage write data |
| st_we | output | 1 | Storage write enable |
| rm_addr | output | RM_AW | Register-map address |
| rm_rdata | input | 8 | Register-map read data |
| rm_wdata | output | 8 | Register-map write data |
| rm_we | output | 1 | Register-map write enable |
| upd_stb | output | 1 | Register update strobe |
| cal_stb | output | 1 | Calibration strobe |
| sync_stb | output | 1 | Distribution sync strobe |

## Verification
The hardest situation to reach is a stored image built from several appended segments, each cut short by a pause, that is loaded back with tags left over from earlier condition opcodes. That load must skip some transfers and still stay aligned with the stream. Random programs are saved in chains of up to three pause-joined segments. Only then is the image loaded with a random condition selection. The loaded result is compared with a bench interpreter over the whole register map. Directed runs cover a start pulse during a run, tags left set at the end of one load, and a pause overwritten by the next segment.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OP, ST_AHI, ST_ALO, ST_XFER
  } seq_state_t;

  typedef enum logic [2:0] {
    OP_MOVE, OP_UPD, OP_CAL, OP_SYNC, OP_COND, OP_PAUSE, OP_END, OP_NOP
  } op_kind_t;

  // Sort one stream byte into its opcode class; ncond bounds the condition range.
  function automatic op_kind_t op_class(input logic [7:0] b, input int unsigned ncond);
    if (!b[7])                                   return OP_MOVE;
    if (b == 8'h80)                              return OP_UPD;
    if (b == 8'hA0)                              return OP_CAL;
    if (b == 8'hA1)                              return OP_SYNC;
    if (b == 8'hFE)                              return OP_PAUSE;
    if (b == 8'hFF)                              return OP_END;
    if (b >= 8'hB0 && 32'(b - 8'hB0) <= ncond)   return OP_COND;
    return OP_NOP;
  endfunction

  // Condition slot carried by a condition opcode (0 = clear all).
  function automatic logic [3:0] cond_slot(input logic [7:0] b);
    return 4'(b - 8'hB0);
  endfunction

endpackage

// File: rtl/bcs_decode.sv
module bcs_decode
  import bcs_pkg::*;
#(
  parameter int unsigned NCOND = 8
) (
  input  logic [7:0] op_byte,
  output op_kind_t   kind,
  output logic [3:0] slot
);
  always_comb begin
    kind = op_class(op_byte, NCOND);
    slot = cond_slot(op_byte);
  end
endmodule

// File: rtl/bcs_tagboard.sv
module bcs_tagboard #(
  parameter int unsigned NCOND = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       wr,
  input  logic [3:0] idx,
  input  logic [3:0] sel,
  output logic       exec_ok,
  output logic       cond_live
);
  logic [NCOND-1:0] tags;
  logic             hit;

  for (genvar g = 0; g < NCOND; g++) begin : g_tag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          tags[g] <= 1'b0;
      else if (clr || (wr && idx == 4'd0)) tags[g] <= 1'b0;
      else if (wr && idx == 4'(g + 1))     tags[g] <= 1'b1;
    end
  end

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < int'(NCOND); i++)
      if (sel == 4'(i + 1)) hit = tags[i];
  end

  assign cond_live = |tags;
  assign exec_ok   = !cond_live || hit;
endmodule

// File: rtl/bcs_stptr.sv
module bcs_stptr #(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_save,
  input  logic          go_load,
  input  logic          step,
  input  logic          pause_mark,
  input  logic          end_mark,
  output logic [AW-1:0] ptr,
  output logic          appending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      appending <= 1'b0;
    end else if (go_load) begin
      ptr       <= '0;
      appending <= 1'b0;
    end else if (go_save) begin
      if (!appending) ptr <= '0;
    end else begin
      if (step)       ptr       <= ptr + AW'(1);
      if (pause_mark) appending <= 1'b1;
      if (end_mark)   appending <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_bytecode_seq.sv
module cfg_bytecode_seq
  import bcs_pkg::*;
#(
  parameter int unsigned SP_AW = 8,
  parameter int unsigned ST_AW = 10,
  parameter int unsigned RM_AW = 12,
  parameter int unsigned NCOND = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_save,
  input  logic [3:0]       sel_cond,
  output logic             busy,
  output logic             done,
  output logic [SP_AW-1:0] sp_addr,
  input  logic [7:0]       sp_rdata,
  output logic [ST_AW-1:0] st_addr,
  input  logic [7:0]       st_rdata,
  output logic [7:0]       st_wdata,
  output logic             st_we,
  output logic [RM_AW-1:0] rm_addr,
  input  logic [7:0]       rm_rdata,
  output logic [7:0]       rm_wdata,
  output logic             rm_we,
  output logic             upd_stb,
  output logic             cal_stb,
  output logic             sync_stb
);
  localparam int unsigned CW = 7;

  seq_state_t       state;
  logic             mode_save;
  logic [CW-1:0]    cnt;
  logic [7:0]       addr_hi;
  logic [RM_AW-1:0] raddr;
  logic [SP_AW-1:0] sp_ptr;
  logic [ST_AW-1:0] ptr;
  logic             appending;

  // Named internal events
  logic [7:0] src;
  op_kind_t   kind;
  logic [3:0] slot;
  logic       in_op, go, op_stop, xfer_last, exec_ok, cond_live;
  logic       pause_mark, end_mark, step;

  assign busy      = (state != ST_IDLE);
  assign src       = mode_save ? sp_rdata : st_rdata;
  assign in_op     = (state == ST_OP);
  assign go        = start && (state == ST_IDLE);
  assign op_stop   = in_op && (kind == OP_PAUSE || kind == OP_END);
  assign xfer_last = (state == ST_XFER) && (cnt == '0);
  assign pause_mark = in_op && mode_save && (kind == OP_PAUSE);
  assign end_mark   = in_op && mode_save && (kind == OP_END);
  assign step       = busy && !pause_mark;

  bcs_decode #(.NCOND(NCOND)) u_dec (
    .op_byte (src),
    .kind    (kind),
    .slot    (slot)
  );

  bcs_tagboard #(.NCOND(NCOND)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (go),
    .wr        (in_op && kind == OP_COND),
    .idx       (slot),
    .sel       (sel_cond),
    .exec_ok   (exec_ok),
    .cond_live (cond_live)
  );

  bcs_stptr #(.AW(ST_AW)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_save    (go && dir_save),
    .go_load    (go && !dir_save),
    .step       (step),
    .pause_mark (pause_mark),
    .end_mark   (end_mark),
    .ptr        (ptr),
    .appending  (appending)
  );

  // Memory ports
  assign sp_addr  = sp_ptr;
  assign st_addr  = ptr;
  assign st_we    = busy && mode_save;
  assign st_wdata = (state == ST_XFER) ? rm_rdata : sp_rdata;
  assign rm_addr  = raddr;
  assign rm_wdata = st_rdata;
  assign rm_we    = (state == ST_XFER) && !mode_save && exec_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      mode_save <= 1'b0;
      cnt       <= '0;
      addr_hi   <= '0;
      raddr     <= '0;
      sp_ptr    <= '0;
      done      <= 1'b0;
      upd_stb   <= 1'b0;
      cal_stb   <= 1'b0;
      sync_stb  <= 1'b0;
    end else begin
      done     <= op_stop;
      upd_stb  <= in_op && !mode_save && (kind == OP_UPD);
      cal_stb  <= in_op && !mode_save && (kind == OP_CAL);
      sync_stb <= in_op && !mode_save && (kind == OP_SYNC);
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_OP;
            mode_save <= dir_save;
            sp_ptr    <= '0;
          end
        end
        ST_OP: begin
          if (mode_save) sp_ptr <= sp_ptr + SP_AW'(1);
          if (kind == OP_MOVE) begin
            cnt   <= src[CW-1:0];
            state <= ST_AHI;
          end else if (op_stop) begin
            state <= ST_IDLE;
          end
        end
        ST_AHI: begin
          addr_hi <= src;
          if (mode_save) sp_ptr <= sp_ptr + SP_AW'(1);
          state <= ST_ALO;
        end
        ST_ALO: begin
          raddr <= RM_AW'({addr_hi, src});
          if (mode_save) sp_ptr <= sp_ptr + SP_AW'(1);
          state <= ST_XFER;
        end
        ST_XFER: begin
          raddr <= raddr + RM_AW'(1);
          if (xfer_last) state <= ST_OP;
          else           cnt   <= cnt - CW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
  parameter int unsigned NCOND = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       st_we,
  input logic       rm_we,
  input logic       upd_stb,
  input logic       cal_stb,
  input logic       sync_stb,
  input logic       mode_save,
  input logic       cond_live,
  input logic [3:0] sel_cond
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!st_we && !rm_we));
  // R2
  save_only_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> (busy && mode_save));
  // R3
  load_only_rmw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rm_we |-> (busy && !mode_save));
  // R4
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({upd_stb, cal_stb, sync_stb}));
  // R4
  strobe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb || cal_stb || sync_stb) |-> (busy && !mode_save));
  // R5
  cond_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_we && cond_live) |-> (sel_cond != 4'd0 && 32'(sel_cond) <= NCOND));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind cfg_bytecode_seq bcs_chk #(.NCOND(NCOND)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .st_we     (st_we),
  .rm_we     (rm_we),
  .upd_stb   (upd_stb),
  .cal_stb   (cal_stb),
  .sync_stb  (sync_stb),
  .mode_save (mode_save),
  .cond_live (cond_live),
  .sel_cond  (sel_cond)
);

// File: tb/sim_cfg_bytecode_seq.sv
module sim_cfg_bytecode_seq;
  localparam int SP_AW = 8, ST_AW = 10, RM_AW = 12, NC = 8;
  localparam int SPN = 1 << SP_AW, STN = 1 << ST_AW, RMN = 1 << RM_AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, dir_save, busy, done, st_we, rm_we, upd_stb, cal_stb, sync_stb;
  logic [3:0] sel_cond;
  logic [SP_AW-1:0] sp_addr;
  logic [ST_AW-1:0] st_addr;
  logic [RM_AW-1:0] rm_addr;
  logic [7:0] sp_rdata, st_rdata, st_wdata, rm_rdata, rm_wdata;

  logic [7:0] spm [SPN];
  logic [7:0] stm [STN];
  logic [7:0] rmm [RMN];
  logic [7:0] exp_st [STN];
  logic [7:0] exp_rm [RMN];

  cfg_bytecode_seq #(.SP_AW(SP_AW), .ST_AW(ST_AW), .RM_AW(RM_AW), .NCOND(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_save(dir_save), .sel_cond(sel_cond),
    .busy(busy), .done(done), .sp_addr(sp_addr), .sp_rdata(sp_rdata),
    .st_addr(st_addr), .st_rdata(st_rdata), .st_wdata(st_wdata), .st_we(st_we),
    .rm_addr(rm_addr), .rm_rdata(rm_rdata), .rm_wdata(rm_wdata), .rm_we(rm_we),
    .upd_stb(upd_stb), .cal_stb(cal_stb), .sync_stb(sync_stb));

  assign sp_rdata = spm[sp_addr];
  assign st_rdata = stm[st_addr];
  assign rm_rdata = rmm[rm_addr];
  always @(posedge clk) begin
    if (st_we) stm[st_addr] <= st_wdata;
    if (rm_we) rmm[rm_addr] <= rm_wdata;
  end

  int n_tests = 0, n_fail = 0, cyc = 0;
  int got_s [256];
  int exp_s [256];
  int n_got = 0, n_exp = 0;
  int m_app = 0, m_ptr = 0, wi = 0;

  // Strobe log, sampled mid-cycle
  always @(negedge clk) begin
    if ((upd_stb + cal_stb + sync_stb) > 1) begin
      got_s[n_got % 256] = 9; n_got++;
    end else if (upd_stb) begin got_s[n_got % 256] = 1; n_got++; end
    else if (cal_stb)  begin got_s[n_got % 256] = 2; n_got++; end
    else if (sync_stb) begin got_s[n_got % 256] = 3; n_got++; end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_tests++;
      $display("FAIL R9 watchdog: actual=%0d cycles expected=below 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic emit(input int b);
    spm[wi] = 8'(b); wi++;
  endtask

  task automatic sync_rm();
    for (int k = 0; k < RMN; k++) exp_rm[k] = rmm[k];
  endtask

  // Bench interpreter, save direction
  task automatic m_save();
    int p, i, n, a;
    logic [7:0] b;
    p = m_app ? m_ptr : 0; i = 0;
    forever begin
      b = spm[i];
      exp_st[p % STN] = b;
      if (b < 8'h80) begin
        n = int'(b);
        exp_st[(p + 1) % STN] = spm[i + 1];
        exp_st[(p + 2) % STN] = spm[i + 2];
        a = int'({spm[i + 1], spm[i + 2]}) % RMN;
        for (int k = 0; k <= n; k++) exp_st[(p + 3 + k) % STN] = exp_rm[(a + k) % RMN];
        p += 4 + n; i += 3;
      end else if (b == 8'hFE) begin
        m_app = 1; m_ptr = p; break;
      end else if (b == 8'hFF) begin
        m_app = 0; break;
      end else begin
        p++; i++;
      end
    end
  endtask

  // Bench interpreter, load direction
  task automatic m_load(input int sel);
    int p, n, a, tags;
    bit run;
    logic [7:0] b;
    p = 0; tags = 0; n_exp = 0; m_app = 0;
    while (p < STN) begin
      b = exp_st[p];
      if (b < 8'h80) begin
        n = int'(b);
        a = int'({exp_st[p + 1], exp_st[p + 2]}) % RMN;
        run = (tags == 0) || (sel >= 1 && sel <= NC && ((tags >> (sel - 1)) & 1) == 1);
        if (run) for (int k = 0; k <= n; k++) exp_rm[(a + k) % RMN] = exp_st[(p + 3 + k) % STN];
        p += 4 + n;
      end else begin
        if (b == 8'h80) begin exp_s[n_exp] = 1; n_exp++; end
        else if (b == 8'hA0) begin exp_s[n_exp] = 2; n_exp++; end
        else if (b == 8'hA1) begin exp_s[n_exp] = 3; n_exp++; end
        else if (b == 8'hB0) tags = 0;
        else if (b >= 8'hB1 && b <= 8'hB8) tags = tags | (1 << int'(b - 8'hB1));
        else if (b == 8'hFE || b == 8'hFF) break;
        p++;
      end
    end
  endtask

  task automatic do_run(input bit save, input int sel, input bit poke);
    int k;
    n_got = 0;
    @(negedge clk);
    dir_save = save; sel_cond = 4'(sel); start = 1'b1;
    @(negedge clk);
    start = 1'b0; k = 0;
    while (!done && k < 5000) begin
      @(negedge clk);
      k++;
      start = (poke && k == 3);
    end
    start = 1'b0;
    chk(done == 1'b1, "R9", "done seen", done, 1);
    chk(busy == 1'b0, "R9", "busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one cycle", done, 0);
    chk(busy == 1'b0, "R9", "stays idle after done", busy, 0);
  endtask

  task automatic save_run(input bit poke);
    int mism;
    m_save();
    do_run(1'b1, 0, poke);
    mism = 0;
    for (int k = 0; k < STN; k++) if (stm[k] !== exp_st[k]) mism++;
    chk(mism == 0, "R2", "storage image mismatches", mism, 0);
    chk(n_got == 0, "R4", "strobes during save", n_got, 0);
  endtask

  task automatic load_run(input int sel);
    int mism;
    m_load(sel);
    do_run(1'b0, sel, 1'b0);
    mism = 0;
    for (int k = 0; k < RMN; k++) if (rmm[k] !== exp_rm[k]) mism++;
    chk(mism == 0, "R3", "register map mismatches", mism, 0);
    chk(n_got == n_exp, "R4", "strobe count", n_got, n_exp);
    mism = 0;
    for (int k = 0; k < n_exp && k < n_got; k++) if (got_s[k] != exp_s[k]) mism++;
    chk(mism == 0, "R4", "strobe order mismatches", mism, 0);
    sync_rm();
  endtask

  function automatic bit is_filler(input int b);
    return b >= 8'h81 && b != 8'hA0 && b != 8'hA1 && b < 8'hFE && !(b >= 8'hB0 && b <= 8'hB8);
  endfunction

  task automatic build_random(input int ending);
    int sb, r, n, f;
    wi = 0; sb = 0;
    while (sb < 200 && wi < 200) begin
      r = int'($urandom % 10);
      if (r < 4) begin
        n = int'($urandom % 8);
        emit(n); emit(int'($urandom % 16)); emit(int'($urandom % 256));
        sb += 4 + n;
      end else if (r < 6) begin
        r = int'($urandom % 3);
        emit(r == 0 ? 8'h80 : (r == 1 ? 8'hA0 : 8'hA1)); sb++;
      end else if (r < 8) begin
        emit(8'hB0 + int'($urandom % 9)); sb++;
      end else begin
        f = int'($urandom % 256);
        while (!is_filler(f)) f = int'($urandom % 256);
        emit(f); sb++;
      end
    end
    emit(ending);
  endtask

  initial begin
    int pauses, endb;
    void'($urandom(32'd5151));
    for (int k = 0; k < SPN; k++) spm[k] = 8'h00;
    for (int k = 0; k < STN; k++) begin stm[k] = 8'h00; exp_st[k] = 8'h00; end
    for (int k = 0; k < RMN; k++) rmm[k] = 8'(k * 7 + 3);
    sync_rm();
    rst_n = 1'b0; start = 1'b0; dir_save = 1'b0; sel_cond = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk({upd_stb, cal_stb, sync_stb} == 3'b000, "R1", "strobes after reset", {upd_stb, cal_stb, sync_stb}, 0);
    chk(!st_we && !rm_we, "R1", "writes after reset", {st_we, rm_we}, 0);

    // R5 R6 R4 directed: conditional skip, clear, no-op codes, strobe order
    rmm[12'h123] = 8'h5A; rmm[12'h124] = 8'h5B; rmm[12'h200] = 8'h77; rmm[12'h300] = 8'h66;
    sync_rm();
    wi = 0;
    emit(8'hB3); emit(8'h01); emit(8'h01); emit(8'h23);
    emit(8'hB0); emit(8'hA0); emit(8'h00); emit(8'h02); emit(8'h00);
    emit(8'hC5); emit(8'h90); emit(8'h80);
    emit(8'h00); emit(8'h03); emit(8'h00); emit(8'hA1); emit(8'hB1); emit(8'hFF);
    save_run(1'b1);  // R9 start pulse while busy is ignored
    rmm[12'h123] = 8'h00; rmm[12'h124] = 8'h00; rmm[12'h200] = 8'h00; rmm[12'h300] = 8'h00;
    sync_rm();
    load_run(2);
    chk(rmm[12'h123] == 8'h00, "R5", "skipped untagged transfer", rmm[12'h123], 0);
    chk(rmm[12'h124] == 8'h00, "R5", "skipped untagged transfer tail", rmm[12'h124], 0);
    chk(rmm[12'h200] == 8'h77, "R5", "transfer after clear", rmm[12'h200], 8'h77);
    chk(rmm[12'h300] == 8'h66, "R6", "transfer after no-op codes", rmm[12'h300], 8'h66);
    chk(n_got == 3 && got_s[0] == 2 && got_s[1] == 1 && got_s[2] == 3, "R4", "strobe sequence",
        got_s[0] * 100 + got_s[1] * 10 + got_s[2], 213);

    // R10: tags left set by one load must not gate the next
    rmm[12'h400] = 8'h3C; sync_rm();
    wi = 0;
    emit(8'h00); emit(8'h04); emit(8'h00); emit(8'hB1); emit(8'hFF);
    save_run(1'b0);
    rmm[12'h400] = 8'h00; sync_rm();
    load_run(2);
    rmm[12'h400] = 8'h00; sync_rm();
    load_run(2);
    chk(rmm[12'h400] == 8'h3C, "R10", "second load with cleared tags", rmm[12'h400], 8'h3C);

    // R7: pause keeps the pointer, next segment overwrites the pause byte
    wi = 0; emit(8'hA0); emit(8'hFE);
    save_run(1'b0);
    chk(stm[1] == 8'hFE, "R7", "pause byte stored", stm[1], 8'hFE);
    wi = 0; emit(8'hA1); emit(8'hFF);
    save_run(1'b0);
    chk(stm[1] == 8'hA1, "R7", "append at pause address", stm[1], 8'hA1);
    load_run(0);

    // R8: end resets the pointer for the next save
    wi = 0; emit(8'h80); emit(8'hFF);
    save_run(1'b0);
    chk(stm[0] == 8'h80, "R8", "save after end starts at 0", stm[0], 8'h80);

    // Random chains of segments, then a load with a random condition selection
    pauses = 0;
    for (int it = 0; it < 24; it++) begin
      endb = (pauses < 2 && ($urandom % 2) == 1) ? 8'hFE : 8'hFF;
      build_random(endb);
      save_run(it % 5 == 0);
      if (endb == 8'hFE) pauses++;
      else begin
        pauses = 0;
        for (int k = 0; k < RMN; k++) rmm[k] = 8'($urandom);
        sync_rm();
        load_run(int'($urandom % 10));
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule